// File: doc/BRIEF.md
# Carry-Chain Permuted Counter Random Byte Generator

This block produces one pseudo-random byte each time it is asked. Its state is a row of byte registers. Every update is a single pass of additions across that row. A running sum starts at a fixed odd increment, and each addition feeds its carry into the next one. At one point in the row, the running sum is XORed with the old value of the last byte before the update continues. This breaks up the regular patterns that a plain add chain leaves in the low-order bits.

The new last byte XORed with the new byte at the mix point gives the output byte. A seed input overwrites the whole state in one clock. A strobe advances the state by exactly one update per clock and presents the result on a registered output, with a valid flag that pulses one cycle later. With the default shape (seven 8-bit bytes, increment 0x45, mix before byte 4), the period is at least 2^32 outputs.

Top module: `acc_perm_rng`

## Requirements
- R1: Reset sets every state byte, the output byte and the valid flag to zero. From that state, the first update yields output 0x00 with the default parameters.
- R2: Each update first adds the increment to byte 0 with a carry-in of zero, stores the low bits in byte 0, and passes the carry-out on. The increment must be odd; an even value is rejected when the block is elaborated. With byte 0 at 0xFF and increment 0x45, byte 0 becomes 0x44 and the carry is 1.
- R3: For each byte index from 1 up to the one before the mix point, the new byte is the running sum plus the old byte plus the incoming carry, truncated to the byte width. That result becomes the new running sum, and its carry goes to the next stage.
- R4: Just before the byte at the mix point is updated, the running sum is XORed with the pre-update value of the last byte, and the carry is kept across the XOR. From the zero state, the second default update gives output 0x8A.
- R5: The bytes from the mix point up to the last are updated by the same add-with-carry rule, continuing the same running sum and carry.
- R6: The output byte equals the new last byte XOR the new byte at the mix point. It appears in the clock after the strobe is sampled, with the valid flag high for exactly that cycle.
- R7: While the strobe stays high, the state advances once per clock and a fresh output with valid is produced every cycle.
- R8: A seed load writes byte i from seed bits [i*W +: W], where W is the byte width. It wins over a strobe in the same cycle and produces no valid output.
- R9: With neither strobe nor load, the state and the output byte hold their values and valid stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load the whole state from `seed` |
| seed | input | BYTE_W*N_BYTES | New state; byte i in bits [i*BYTE_W +: BYTE_W] |
| next | input | 1 | Perform one update and produce one output |
| rnd | output | BYTE_W | Last generated byte |
| rnd_valid | output | 1 | High for one cycle after each update |

## Verification
The bench builds two instances. The first uses the default shape (seven 8-bit bytes, increment 0x45, mix before byte 4). It is run from the zero state, from chosen seeds that force carries across every byte, and through twenty thousand back-to-back updates. The second uses four 3-bit bytes with increment 3 and the mix before byte 2. That small shape makes a sweep over all 4096 possible seeds practical, so every carry and mix combination on a short chain is reached, followed by a long continuous run. A bench-side arithmetic model of the add-and-mix pass supplies every expected byte.

// File: rtl/rng_pkg.sv
`timescale 1ns/1ps
package rng_pkg;

   localparam int unsigned DEF_BYTE_W  = 8;
   localparam int unsigned DEF_N_BYTES = 7;
   localparam int unsigned DEF_MIX_IDX = 4;
   localparam int unsigned DEF_INCR    = 32'h45;

   // action decoded from the control inputs each cycle
   typedef enum logic [1:0] {
      ACT_IDLE = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_STEP = 2'd2
   } act_e;

   function automatic bit incr_is_odd(input int unsigned v);
      return (v % 2) == 1;
   endfunction

endpackage

// File: rtl/rng_add_stage.sv
`timescale 1ns/1ps
// one byte of the carry chain: sum = running + old + carry
module rng_add_stage #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] run_in,
   input  logic [W-1:0] old_byte,
   input  logic         carry_in,
   output logic [W-1:0] sum_out,
   output logic         carry_out
);

   logic [W:0] wide;

   assign wide      = {1'b0, run_in} + {1'b0, old_byte} + {{W{1'b0}}, carry_in};
   assign sum_out   = wide[W-1:0];
   assign carry_out = wide[W];

endmodule

// File: rtl/rng_chain.sv
`timescale 1ns/1ps
// full combinational update pass over all state bytes
module rng_chain #(
   parameter int unsigned W       = 8,
   parameter int unsigned N       = 7,
   parameter int unsigned MIX_IDX = 4,
   parameter int unsigned INCR    = 32'h45
) (
   input  logic [N*W-1:0] st_in,
   output logic [N*W-1:0] st_out
);

   localparam logic [W-1:0] INCR_B = W'(INCR);
   localparam int unsigned  TOP    = N - 1;

   logic [W-1:0] run   [N+1];
   logic [W-1:0] pre   [N];
   logic         carry [N];
   logic [W-1:0] top_old;

   assign top_old  = st_in[TOP*W +: W];
   assign run[0]   = INCR_B;
   assign carry[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_byte
      if (i == MIX_IDX) begin : g_mix
         assign pre[i] = run[i] ^ top_old;
      end else begin : g_pass
         assign pre[i] = run[i];
      end

      if (i < TOP) begin : g_add
         rng_add_stage #(.W(W)) u_add (
            .run_in   (pre[i]),
            .old_byte (st_in[i*W +: W]),
            .carry_in (carry[i]),
            .sum_out  (run[i+1]),
            .carry_out(carry[i+1])
         );
      end else begin : g_last
         // final carry leaves the chain, so only the byte is formed
         assign run[i+1] = pre[i] + st_in[i*W +: W] + {{(W-1){1'b0}}, carry[i]};
      end

      assign st_out[i*W +: W] = run[i+1];
   end

endmodule

// File: rtl/rng_out_reg.sv
`timescale 1ns/1ps
// registered output byte with single-cycle valid
module rng_out_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fire,
   input  logic [W-1:0] value,
   output logic [W-1:0] rnd,
   output logic         rnd_valid
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rnd       <= '0;
         rnd_valid <= 1'b0;
      end else begin
         rnd_valid <= fire;
         if (fire) begin
            rnd <= value;
         end
      end
   end

endmodule

// File: rtl/acc_perm_rng.sv
`timescale 1ns/1ps
module acc_perm_rng
   import rng_pkg::*;
#(
   parameter int unsigned BYTE_W  = DEF_BYTE_W,
   parameter int unsigned N_BYTES = DEF_N_BYTES,
   parameter int unsigned MIX_IDX = DEF_MIX_IDX,
   parameter int unsigned INCR    = DEF_INCR
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        seed_load,
   input  logic [BYTE_W*N_BYTES-1:0]   seed,
   input  logic                        next,
   output logic [BYTE_W-1:0]           rnd,
   output logic                        rnd_valid
);

   localparam int unsigned STATE_W = BYTE_W * N_BYTES;
   localparam int unsigned TOP     = N_BYTES - 1;

   // elaboration-time parameter checks
   if (BYTE_W < 2 || BYTE_W > 16) begin : g_bad_width
      $error("acc_perm_rng: BYTE_W out of range");
   end
   if (N_BYTES < 3) begin : g_bad_count
      $error("acc_perm_rng: N_BYTES must be at least 3");
   end
   if (MIX_IDX < 1 || MIX_IDX > N_BYTES - 2) begin : g_bad_mix
      $error("acc_perm_rng: MIX_IDX must lie in 1..N_BYTES-2");
   end
   if (!incr_is_odd(INCR)) begin : g_even_incr
      $error("acc_perm_rng: INCR must be odd");
   end
   if (INCR >= (32'd1 << BYTE_W)) begin : g_wide_incr
      $error("acc_perm_rng: INCR does not fit in one byte");
   end

   act_e               act;
   logic [STATE_W-1:0] state_q;
   logic [STATE_W-1:0] state_nxt;
   logic [BYTE_W-1:0]  out_val;

   always_comb begin
      if (seed_load) begin
         act = ACT_LOAD;
      end else if (next) begin
         act = ACT_STEP;
      end else begin
         act = ACT_IDLE;
      end
   end

   rng_chain #(
      .W      (BYTE_W),
      .N      (N_BYTES),
      .MIX_IDX(MIX_IDX),
      .INCR   (INCR)
   ) u_chain (
      .st_in (state_q),
      .st_out(state_nxt)
   );

   assign out_val = state_nxt[TOP*BYTE_W +: BYTE_W] ^ state_nxt[MIX_IDX*BYTE_W +: BYTE_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= '0;
      end else begin
         unique case (act)
            ACT_LOAD: state_q <= seed;
            ACT_STEP: state_q <= state_nxt;
            default:  state_q <= state_q;
         endcase
      end
   end

   rng_out_reg #(.W(BYTE_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (act == ACT_STEP),
      .value    (out_val),
      .rnd      (rnd),
      .rnd_valid(rnd_valid)
   );

endmodule

// File: rtl/acc_perm_rng_chk.sv
`timescale 1ns/1ps
module acc_perm_rng_chk #(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned N_BYTES = 7,
   parameter int unsigned MIX_IDX = 4,
   parameter int unsigned INCR    = 32'h45
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      seed_load,
   input logic [BYTE_W*N_BYTES-1:0] seed,
   input logic                      next,
   input logic [BYTE_W-1:0]         rnd,
   input logic                      rnd_valid,
   input logic [BYTE_W*N_BYTES-1:0] state
);

   localparam int unsigned TOP = N_BYTES - 1;

   // R2: byte 0 advances by the increment on every update
   a_r2_first_byte_adds: assert property (@(posedge clk) disable iff (!rst_n)
      (next && !seed_load) |=> state[BYTE_W-1:0] == $past(state[BYTE_W-1:0]) + BYTE_W'(INCR));

   // R6: output is formed from the new last byte and the new mix byte
   a_r6_output_form: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_valid |-> rnd == (state[TOP*BYTE_W +: BYTE_W] ^ state[MIX_IDX*BYTE_W +: BYTE_W]));

   // R6 / R7: valid follows a sampled strobe
   a_r6_valid_after_next: assert property (@(posedge clk) disable iff (!rst_n)
      (next && !seed_load) |=> rnd_valid);

   // R8: loading copies the seed and gives no output
   a_r8_seed_copied: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |=> (state == $past(seed)) && !rnd_valid);

   // R9: idle cycles hold state and output
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!seed_load && !next) |=> $stable(state) && $stable(rnd) && !rnd_valid);

endmodule

bind acc_perm_rng acc_perm_rng_chk #(
   .BYTE_W (BYTE_W),
   .N_BYTES(N_BYTES),
   .MIX_IDX(MIX_IDX),
   .INCR   (INCR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .seed_load(seed_load),
   .seed     (seed),
   .next     (next),
   .rnd      (rnd),
   .rnd_valid(rnd_valid),
   .state    (state_q)
);

// File: tb/sim_acc_perm_rng.sv
`timescale 1ns/1ps
module sim_acc_perm_rng;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   // default shape
   logic        sl0 = 1'b0, nx0 = 1'b0, v0;
   logic [55:0] sd0 = '0;
   logic [7:0]  rnd0;
   // small shape: 4 bytes of 3 bits, incr 3, mix before byte 2
   logic        sl1 = 1'b0, nx1 = 1'b0, v1;
   logic [11:0] sd1 = '0;
   logic [2:0]  rnd1;

   acc_perm_rng u0 (
      .clk(clk), .rst_n(rst_n), .seed_load(sl0), .seed(sd0), .next(nx0),
      .rnd(rnd0), .rnd_valid(v0)
   );

   acc_perm_rng #(.BYTE_W(3), .N_BYTES(4), .MIX_IDX(2), .INCR(3)) u1 (
      .clk(clk), .rst_n(rst_n), .seed_load(sl1), .seed(sd1), .next(nx1),
      .rnd(rnd1), .rnd_valid(v1)
   );

   int unsigned n_chk = 0;
   int unsigned n_fail = 0;
   bit          done = 1'b0;
   logic [63:0] m0 = '0;
   logic [63:0] m1 = '0;

   function automatic logic [63:0] mstep(input logic [63:0] st, input int w, input int n,
                                         input int mix, input int incr, output logic [7:0] o);
      logic [63:0] ns;
      int unsigned mask, run, c, old, tmp, top;
      mask = (32'd1 << w) - 1;
      run  = incr;
      c    = 0;
      ns   = st;
      top  = 32'(st >> ((n - 1) * w)) & mask;
      for (int i = 0; i < n; i++) begin
         old = 32'(st >> (i * w)) & mask;
         if (i == mix) run = run ^ top;
         tmp = run + old + c;
         run = tmp & mask;
         c   = tmp >> w;
         ns  = (ns & ~(64'(mask) << (i * w))) | (64'(run) << (i * w));
      end
      o = 8'((32'(ns >> ((n - 1) * w)) ^ 32'(ns >> (mix * w))) & mask);
      return ns;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step0(input string req);
      logic [7:0] e;
      @(negedge clk) nx0 = 1'b1;
      @(negedge clk) nx0 = 1'b0;
      m0 = mstep(m0, 8, 7, 4, 'h45, e);
      chk(v0 == 1'b1, req, 64'(v0), 64'd1);
      chk(rnd0 == e, req, 64'(rnd0), 64'(e));
   endtask

   task automatic load0(input logic [55:0] s);
      @(negedge clk) begin sl0 = 1'b1; sd0 = s; end
      @(negedge clk) sl0 = 1'b0;
      m0 = 64'(s);
      chk(v0 == 1'b0, "R8 load gives no valid", 64'(v0), 64'd0);
   endtask

   task automatic step1(input string req);
      logic [7:0] e;
      @(negedge clk) nx1 = 1'b1;
      @(negedge clk) nx1 = 1'b0;
      m1 = mstep(m1, 3, 4, 2, 3, e);
      chk(v1 == 1'b1 && 8'(rnd1) == e, req, 64'(rnd1), 64'(e));
   endtask

   task automatic load1(input logic [11:0] s);
      @(negedge clk) begin sl1 = 1'b1; sd1 = s; end
      @(negedge clk) sl1 = 1'b0;
      m1 = 64'(s);
   endtask

   initial begin
      logic [7:0] held;
      logic [7:0] e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset values
      chk(rnd0 == 8'h00 && v0 == 1'b0, "R1 reset output", {rnd0, 7'd0, v0}, 64'd0);
      chk(rnd1 == 3'd0 && v1 == 1'b0, "R1 reset output small", {rnd1, 7'd0, v1}, 64'd0);
      // R1 first update from zero state gives 0x00
      step0("R1 first update");
      chk(rnd0 == 8'h00, "R1 hand value", 64'(rnd0), 64'h00);
      // R4 second update from zero gives 0x8A
      step0("R4 second update");
      chk(rnd0 == 8'h8A, "R4 hand value", 64'(rnd0), 64'h8A);
      // R2 carry out of byte 0 (0xFF + 0x45)
      load0(56'h000000000000FF);
      step0("R2 carry from byte 0");
      // R3 / R5 carries across every byte
      load0(56'hFFFFFFFFFFFFFF);
      step0("R3 all ones");
      load0(56'h00FFFFFFFFFFBB);
      step0("R3 ripple through");
      load0(56'h80000000000001);
      step0("R5 top byte mix");
      load0(56'h0123456789ABCD);
      step0("R5 mixed seed");
      // R9 idle hold
      held = rnd0;
      repeat (3) @(negedge clk);
      chk(v0 == 1'b0, "R9 valid low when idle", 64'(v0), 64'd0);
      chk(rnd0 == held, "R9 output held", 64'(rnd0), 64'(held));
      step0("R9 state held across idle");
      // R8 load wins over next
      @(negedge clk) begin sl0 = 1'b1; nx0 = 1'b1; sd0 = 56'h5A5A5A5A5A5A5A; end
      @(negedge clk) begin sl0 = 1'b0; nx0 = 1'b0; end
      m0 = 64'h5A5A5A5A5A5A5A;
      chk(v0 == 1'b0, "R8 load beats next", 64'(v0), 64'd0);
      step0("R8 loaded state used");
      // R7 back-to-back updates, default shape
      load0(56'hFFFFFFFFFFFFFF);
      @(negedge clk) nx0 = 1'b1;
      for (int k = 0; k < 20000; k++) begin
         @(negedge clk);
         m0 = mstep(m0, 8, 7, 4, 'h45, e);
         chk(v0 == 1'b1 && rnd0 == e, "R7 continuous run", 64'(rnd0), 64'(e));
      end
      nx0 = 1'b0;
      // R6 exhaustive seed sweep on the small shape
      for (int s = 0; s < 4096; s++) begin
         load1(12'(s));
         step1("R6 small sweep");
      end
      // R7 continuous run on the small shape
      load1(12'h000);
      @(negedge clk) nx1 = 1'b1;
      for (int k = 0; k < 5000; k++) begin
         @(negedge clk);
         m1 = mstep(m1, 3, 4, 2, 3, e);
         chk(v1 == 1'b1 && 8'(rnd1) == e, "R7 small run", 64'(rnd1), 64'(e));
      end
      nx1 = 1'b0;
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule